// File: doc/BRIEF.md
# Aperture Address Remapper

This block translates the addresses issued by one bus master. The 32-bit, 4 GB space is cut into sixteen windows of 256 MB each. Each window is picked by the top four address bits. For each window, a table gives the index of the target slave port and a replacement for the top address nibble. The lower 28 bits go through unchanged. A window whose slave code is zero has no target, and any access to it is flagged as an error.

Software loads the tables through a small word-indexed register port. The writes land in a staged copy of the tables, and that copy reads back at once. The translation in use moves to the staged copy only when the update register is written with bit 0 set. A whole map can therefore be rewritten without the datapath ever seeing a half-written table. The translation result is registered: a request presented in one cycle produces its slave index, translated address and error flag after the next clock edge.

Top module: `aperture_remap`

## Requirements
- R1: The window index of a request is in_addr[31:28], and the window's active slave code and offset nibble are used for that request.
- R2: out_addr[31:28] carries the window's active offset nibble and out_addr[27:0] equals in_addr[27:0]. This holds for mapped and unmapped windows alike.
- R3: Slave codes are written at register index 0 for windows 0..7 and at index 1 for windows 8..15. Window k uses data bits [4*(k%8)+3 : 4*(k%8)].
- R4: Offset nibbles are written at register index 2 for windows 0..7 and at index 3 for windows 8..15, with the same nibble placement as R3.
- R5: Writes to indices 0..3 leave the translation unchanged. A write to index 4 with wdata[0]=1 copies all staged codes and offsets into the active tables at that clock edge. A write to index 4 with wdata[0]=0 copies nothing.
- R6: When the active slave code of the addressed window is 0, out_err is 1 and out_slave is 0. Otherwise out_err is 0 and out_slave is the code.
- R7: After reset, every staged and active code and offset is 0, so every request reports out_err=1 and out_addr[31:28]=0.
- R8: cfg_rdata returns, combinationally, the staged word at cfg_idx, using the packing of R3 and R4, even before any commit. Index 4 and unused indices read 0.
- R9: out_valid is in_valid delayed by one clock. When out_valid is 0, out_err is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write enable |
| cfg_idx | input | 3 | Register word index (byte offset / 4) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Staged register read data |
| in_valid | input | 1 | Request address valid |
| in_addr | input | 32 | Request address |
| out_valid | output | 1 | Translation result valid |
| out_slave | output | 4 | Target slave code, 0 when unmapped |
| out_addr | output | 32 | Translated address |
| out_err | output | 1 | No slave mapped for the addressed window |

## Verification
The hardest state to reach from the ports is a staged table that differs from the active one. In that state, readback shows the new map while translations must still follow the old one. The bench stages a full map while the active table is still at its reset value. It confirms that every probe still errors and that readback already shows the new words. It also writes the update register with bit 0 clear and confirms that nothing changes. Only then does it commit. Later it restages a single window over a live map and probes that window on both sides of the commit edge.

// File: rtl/aperture_remap_pkg.sv
package aperture_remap_pkg;
    localparam int ADDR_W    = 32;
    localparam int NIB       = 4;
    localparam int AP_IDX_W  = 4;
    localparam int N_AP      = 1 << AP_IDX_W;
    localparam int DATA_W    = 32;
    localparam int PER_WORD  = DATA_W / NIB;
    localparam int WORDS     = N_AP / PER_WORD;
    localparam int CFG_IDX_W = 3;
    localparam int SEL_W0    = 0;
    localparam int OFF_W0    = WORDS;
    localparam int UPD_W     = 2 * WORDS;
    localparam int LOW_W     = ADDR_W - AP_IDX_W;

    typedef logic [NIB-1:0]           nib_t;
    typedef nib_t [N_AP-1:0]          table_t;
    typedef logic [CFG_IDX_W-1:0]     cfg_idx_t;
    typedef logic [AP_IDX_W-1:0]      ap_idx_t;

    typedef struct packed {
        logic              valid;
        logic              err;
        nib_t              slave;
        logic [ADDR_W-1:0] addr;
    } xlate_out_t;

    function automatic cfg_idx_t sel_word(int ap);
        return cfg_idx_t'(SEL_W0 + ap / PER_WORD);
    endfunction

    function automatic cfg_idx_t off_word(int ap);
        return cfg_idx_t'(OFF_W0 + ap / PER_WORD);
    endfunction

    function automatic logic [ADDR_W-1:0] swap_top(nib_t off, logic [ADDR_W-1:0] a);
        return {off, a[LOW_W-1:0]};
    endfunction
endpackage

// File: rtl/remap_cfg_regs.sv
module remap_cfg_regs
    import aperture_remap_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  cfg_idx_t            cfg_idx,
    input  logic [DATA_W-1:0]   cfg_wdata,
    output logic [DATA_W-1:0]   cfg_rdata,
    output table_t              act_sel,
    output table_t              act_off
);
    table_t stg_sel, stg_off;
    logic   commit;

    assign commit = cfg_we && (cfg_idx == cfg_idx_t'(UPD_W)) && cfg_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_sel <= '0;
            stg_off <= '0;
            act_sel <= '0;
            act_off <= '0;
        end else begin
            for (int a = 0; a < N_AP; a++) begin
                if (cfg_we && cfg_idx == sel_word(a))
                    stg_sel[a] <= cfg_wdata[(a % PER_WORD)*NIB +: NIB];
                if (cfg_we && cfg_idx == off_word(a))
                    stg_off[a] <= cfg_wdata[(a % PER_WORD)*NIB +: NIB];
            end
            if (commit) begin
                act_sel <= stg_sel;
                act_off <= stg_off;
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        for (int a = 0; a < N_AP; a++) begin
            if (cfg_idx == sel_word(a))
                cfg_rdata[(a % PER_WORD)*NIB +: NIB] = stg_sel[a];
            if (cfg_idx == off_word(a))
                cfg_rdata[(a % PER_WORD)*NIB +: NIB] = stg_off[a];
        end
    end

    AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (rst)
        !(cfg_we && cfg_idx == cfg_idx_t'(UPD_W) && cfg_wdata[0])
        |=> ($stable(act_sel) && $stable(act_off))); // R5

    AST_COMMIT_COPIES: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_idx == cfg_idx_t'(UPD_W) && cfg_wdata[0])
        |=> (act_sel == $past(stg_sel) && act_off == $past(stg_off))); // R5
endmodule

// File: rtl/remap_xlate.sv
module remap_xlate
    import aperture_remap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  table_t            act_sel,
    input  table_t            act_off,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    output xlate_out_t        res
);
    ap_idx_t idx;
    nib_t    sel, off;

    assign idx = in_addr[ADDR_W-1 -: AP_IDX_W];
    assign sel = act_sel[idx];
    assign off = act_off[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            res <= '0;
        end else begin
            res.valid <= in_valid;
            res.err   <= in_valid && (sel == '0);
            res.slave <= sel;
            res.addr  <= swap_top(off, in_addr);
        end
    end

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res.valid); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !res.valid |-> !res.err); // R9

    AST_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res.addr[LOW_W-1:0] == $past(in_addr[LOW_W-1:0])); // R2

    AST_ERR_ZERO_SLAVE: assert property (@(posedge clk) disable iff (rst)
        (res.valid && res.err) |-> res.slave == '0); // R6
endmodule

// File: rtl/aperture_remap.sv
module aperture_remap
    import aperture_remap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [CFG_IDX_W-1:0] cfg_idx,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output logic [DATA_W-1:0]    cfg_rdata,
    input  logic                 in_valid,
    input  logic [ADDR_W-1:0]    in_addr,
    output logic                 out_valid,
    output logic [NIB-1:0]       out_slave,
    output logic [ADDR_W-1:0]    out_addr,
    output logic                 out_err
);
    table_t     act_sel, act_off;
    xlate_out_t res;

    remap_cfg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .act_sel   (act_sel),
        .act_off   (act_off)
    );

    remap_xlate u_xlate (
        .clk      (clk),
        .rst      (rst),
        .act_sel  (act_sel),
        .act_off  (act_off),
        .in_valid (in_valid),
        .in_addr  (in_addr),
        .res      (res)
    );

    assign out_valid = res.valid;
    assign out_err   = res.err;
    assign out_slave = res.err ? '0 : res.slave;
    assign out_addr  = res.addr;
endmodule

// File: tb/test_aperture_remap.sv
module test_aperture_remap;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic        out_valid;
    logic [3:0]  out_slave;
    logic [31:0] out_addr;
    logic        out_err;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    aperture_remap i_aperture_remap (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .in_valid(in_valid), .in_addr(in_addr), .out_valid(out_valid),
        .out_slave(out_slave), .out_addr(out_addr), .out_err(out_err)
    );

    // {in_addr, expected slave, expected err, expected out_addr}
    localparam logic [68:0] VEC [13] = '{
        {32'h0123_4567, 4'd1, 1'b0, 32'h0123_4567},
        {32'h1FFF_FFFF, 4'd1, 1'b0, 32'h1FFF_FFFF},
        {32'h2000_0010, 4'd3, 1'b0, 32'hA000_0010},
        {32'h3ABC_DEF0, 4'd2, 1'b0, 32'h0ABC_DEF0},
        {32'h4000_0000, 4'd0, 1'b1, 32'h0000_0000},
        {32'h8765_4321, 4'd1, 1'b0, 32'h9765_4321},
        {32'h9000_0001, 4'd2, 1'b0, 32'hA000_0001},
        {32'hA123_0000, 4'd3, 1'b0, 32'hB123_0000},
        {32'hB000_0000, 4'd0, 1'b1, 32'h0000_0000},
        {32'hC0DE_CAFE, 4'd4, 1'b0, 32'hC0DE_CAFE},
        {32'hD000_0000, 4'd5, 1'b0, 32'hD000_0000},
        {32'hE555_5555, 4'd6, 1'b0, 32'hE555_5555},
        {32'hFFFF_FFFF, 4'd7, 1'b0, 32'hFFFF_FFFF}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] idx, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_check(string req, logic [2:0] idx, logic [31:0] exp);
        cfg_idx = idx;
        #1;
        check(req, cfg_rdata, exp);
    endtask

    task automatic xlate(logic [31:0] a);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_out(string req, logic [3:0] s, logic e, logic [31:0] a);
        check({req, " valid"}, {31'd0, out_valid}, 32'd1);
        check({req, " slave"}, {28'd0, out_slave}, {28'd0, s});
        check({req, " err"}, {31'd0, out_err}, {31'd0, e});
        check({req, " addr"}, out_addr, a);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R7 reset state, R8 readback of zero staged words
        for (int w = 0; w < 5; w++) rd_check("R7 reset readback", 3'(w), 32'h0);
        xlate(32'h5123_4567);
        expect_out("R7 reset unmapped", 4'd0, 1'b1, 32'h0123_4567);
        // R9 idle cycle after a request
        @(negedge clk);
        check("R9 idle valid", {31'd0, out_valid}, 32'd0);
        check("R9 idle err", {31'd0, out_err}, 32'd0);

        // Stage the map (R3, R4); the active table must stay at reset (R5)
        wr(3'd0, 32'h0000_2311);
        wr(3'd1, 32'h7654_0321);
        wr(3'd2, 32'h0000_0A10);
        wr(3'd3, 32'hFEDC_0BA9);
        rd_check("R8 staged sel lo", 3'd0, 32'h0000_2311);
        rd_check("R8 staged sel hi", 3'd1, 32'h7654_0321);
        rd_check("R8 staged off lo", 3'd2, 32'h0000_0A10);
        rd_check("R8 staged off hi", 3'd3, 32'hFEDC_0BA9);
        rd_check("R8 update reads zero", 3'd4, 32'h0);
        xlate(32'h2000_0010);
        expect_out("R5 staged not active", 4'd0, 1'b1, 32'h0000_0010);
        wr(3'd4, 32'hFFFF_FFFE);
        xlate(32'h2000_0010);
        expect_out("R5 update bit0 clear", 4'd0, 1'b1, 32'h0000_0010);
        wr(3'd4, 32'h0000_0001);

        // Table walk: R1 R2 R3 R4 R6
        foreach (VEC[i]) begin
            xlate(VEC[i][68:37]);
            expect_out("R1 R2 R3 R4 R6 vector", VEC[i][36:33], VEC[i][32], VEC[i][31:0]);
        end

        // Back-to-back requests, R9 one-cycle latency
        @(negedge clk);
        in_valid = 1'b1; in_addr = 32'h8000_0004;
        @(negedge clk);
        in_addr = 32'hB000_0008;
        expect_out("R9 back-to-back first", 4'd1, 1'b0, 32'h9000_0004);
        @(negedge clk);
        in_valid = 1'b0;
        expect_out("R9 back-to-back second", 4'd0, 1'b1, 32'h0000_0008);

        // Restage window 0 over a live map, R5 then commit
        wr(3'd0, 32'h0000_2315);
        wr(3'd2, 32'h0000_0A17);
        xlate(32'h0000_0042);
        expect_out("R5 old map held", 4'd1, 1'b0, 32'h0000_0042);
        rd_check("R8 restaged readback", 3'd0, 32'h0000_2315);
        wr(3'd4, 32'h0000_0001);
        xlate(32'h0000_0042);
        expect_out("R5 new map live", 4'd5, 1'b0, 32'h7000_0042);
        // window 1 unchanged after the commit (R1)
        xlate(32'h1000_0000);
        expect_out("R1 neighbour kept", 4'd1, 1'b0, 32'h1000_0000);

        // Reset again clears both tables (R7)
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd_check("R7 re-reset staged", 3'd1, 32'h0);
        xlate(32'hF000_0000);
        expect_out("R7 re-reset active", 4'd0, 1'b1, 32'h0000_0000);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule